// File: doc/BRIEF.md
# Sample-Strobed Pipelined PI Controller

This block is a fixed-point proportional-integral controller. It runs on a fast system clock, but it computes a new control value only when a single-cycle sample strobe arrives. In the intended system that strobe comes once every 1500 clocks, which gives a 100 kHz loop at 150 MHz. The strobe is the only thing that starts an update.

The strobe acts as a valid bit that travels through the pipeline beside the data. The first stage forms the error. The second stage multiplies the error by both gains. The multiplier is modelled as a multi-cycle unit: its result and its valid bit pass together through a shift delay whose depth is set by a parameter. The next stage updates the integrator. Its feedback select passes the held integrator value only when the valid bit is present and passes zero otherwise, so the integrator moves once per sample. The last stage adds the proportional term to the integrator and saturates the sum.

The data interface is strobe-driven and has no back-pressure. The output valid is a one-cycle pulse, and the consumer must take the value in that cycle. Strobes must be at least `MUL_LAT+4` clocks apart.

Top module: `pi_ctrl`

## Requirements
- R1: On a clock edge where `smp_strobe` is 1, the block captures `setpoint`, `measured`, `kp` and `ki`. It forms the error as `setpoint - measured` in IW+1 signed bits, without overflow. Input changes at any other edge have no effect.
- R2: Each product of the error and a gain is rounded to the nearest value and shifted right arithmetically by FRAC bits: `(x + 2^(FRAC-1)) >>> FRAC`. A tie rounds toward plus infinity.
- R3: The integrator changes at most once per strobe. On every cycle where its valid input is low, it holds its value.
- R4: The integrator adds the rounded integral term and saturates the result to the signed OW-bit range. It never wraps.
- R5: `ctl_out` equals the rounded proportional term plus the updated integrator, saturated to the signed OW-bit range.
- R6: If the previous output sat at the positive limit and the new integral term is positive, the integrator does not change. The same holds at the negative limit with a negative term.
- R7: `ctl_valid` is high for exactly one cycle, in the cycle after the (MUL_LAT+3)-th rising edge. The edge that samples the strobe counts as the first of those edges.
- R8: Between output pulses, `ctl_out` holds its last value.
- R9: A synchronous reset clears the integrator, the saturation flags, `ctl_out` and all valid bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_strobe | input | 1 | One-cycle new-sample strobe |
| setpoint | input | IW | Signed target value |
| measured | input | IW | Signed measured value |
| kp | input | GW | Signed proportional gain, FRAC fractional bits |
| ki | input | GW | Signed integral gain, FRAC fractional bits |
| ctl_out | output | OW | Saturated control value |
| ctl_valid | output | 1 | One-cycle pulse marking a new `ctl_out` |

## Verification
The latency, one-cycle-pulse and hold assertions assume that no strobe arrives while an earlier sample is still inside the pipeline. The stimulus keeps every strobe at least `MUL_LAT+5` cycles after the previous one. The anti-windup assertion assumes that saturation flags from the previous output govern the next sample, which holds at that spacing. After each strobe, the stimulus scrambles the inputs so that sampling at any edge other than the strobe edge would show up in the result.

// File: rtl/pi_pkg.sv
package pi_pkg;
  localparam int WIDE = 48;
  typedef logic signed [WIDE-1:0] wide_t;

  function automatic wide_t clamp(input wide_t x, input int w);
    wide_t hi;
    wide_t lo;
    hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
    lo = -hi - wide_t'(1);
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  function automatic wide_t round_shift(input wide_t x, input int f);
    if (f == 0) return x;
    return (x + (wide_t'(1) <<< (f - 1))) >>> f;
  endfunction
endpackage

// File: rtl/pi_delay_line.sv
module pi_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  input  logic         v_in,
  output logic [W-1:0] d_out,
  output logic         v_out
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign d_out = d_in;
      assign v_out = v_in;
    end else begin : g_shift
      logic [W-1:0] dq [DEPTH];
      logic         vq [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < DEPTH; k++) begin
            dq[k] <= '0;
            vq[k] <= 1'b0;
          end
        end else begin
          dq[0] <= d_in;
          vq[0] <= v_in;
          for (int k = 1; k < DEPTH; k++) begin
            dq[k] <= dq[k-1];
            vq[k] <= vq[k-1];
          end
        end
      end
      assign d_out = dq[DEPTH-1];
      assign v_out = vq[DEPTH-1];

      assert_delay_clear_R9: assert property (@(posedge clk) rst |=> !v_out);
    end
  endgenerate
endmodule

// File: rtl/pi_gain_stage.sv
module pi_gain_stage
  import pi_pkg::*;
#(
  parameter int IW      = 16,
  parameter int GW      = 16,
  parameter int FRAC    = 8,
  parameter int MUL_LAT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strobe,
  input  logic signed [IW-1:0] sp,
  input  logic signed [IW-1:0] meas,
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  output wide_t                p_term,
  output wide_t                i_term,
  output logic                 v_out
);
  localparam int EW = IW + 1;
  localparam int DW = 2 * WIDE;

  logic signed [EW-1:0] err_q;
  logic signed [GW-1:0] kp_q, ki_q;
  logic                 v_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0;
      kp_q  <= '0;
      ki_q  <= '0;
      v_a   <= 1'b0;
    end else begin
      v_a <= strobe;
      if (strobe) begin
        err_q <= EW'(sp) - EW'(meas);
        kp_q  <= kp;
        ki_q  <= ki;
      end
    end
  end

  assert_err_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(err_q));

  wide_t p_b, i_b;
  logic  v_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_b <= '0;
      i_b <= '0;
      v_b <= 1'b0;
    end else begin
      v_b <= v_a;
      p_b <= round_shift(wide_t'(err_q) * wide_t'(kp_q), FRAC);
      i_b <= round_shift(wide_t'(err_q) * wide_t'(ki_q), FRAC);
    end
  end

  logic [DW-1:0] pack_out;

  pi_delay_line #(.W(DW), .DEPTH(MUL_LAT - 1)) u_mul_delay (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({p_b, i_b}),
    .v_in  (v_b),
    .d_out (pack_out),
    .v_out (v_out)
  );

  assign p_term = pack_out[DW-1:WIDE];
  assign i_term = pack_out[WIDE-1:0];
endmodule

// File: rtl/pi_integrator.sv
module pi_integrator
  import pi_pkg::*;
#(
  parameter int OW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  wide_t                p_in,
  input  wide_t                i_in,
  input  logic                 sat_hi,
  input  logic                 sat_lo,
  output logic signed [OW-1:0] acc,
  output wide_t                p_out,
  output logic                 v_out
);
  wide_t fb, add_in, sum;
  logic  block;

  always_comb begin
    fb     = v_in ? wide_t'(acc) : '0;
    add_in = v_in ? i_in : '0;
    sum    = fb + add_in;
    block  = (sat_hi && i_in > 0) || (sat_lo && i_in < 0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      p_out <= '0;
      v_out <= 1'b0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        p_out <= p_in;
        if (!block) acc <= OW'(clamp(sum, OW));
      end
    end
  end

  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> $stable(acc));
  assert_windup_hi_R6: assert property (@(posedge clk) disable iff (rst)
    (v_in && sat_hi && i_in > 0) |=> $stable(acc));
  assert_windup_lo_R6: assert property (@(posedge clk) disable iff (rst)
    (v_in && sat_lo && i_in < 0) |=> $stable(acc));
endmodule

// File: rtl/pi_ctrl.sv
module pi_ctrl
  import pi_pkg::*;
#(
  parameter int IW      = 16,
  parameter int GW      = 16,
  parameter int FRAC    = 8,
  parameter int OW      = 24,
  parameter int MUL_LAT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_strobe,
  input  logic signed [IW-1:0] setpoint,
  input  logic signed [IW-1:0] measured,
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  output logic signed [OW-1:0] ctl_out,
  output logic                 ctl_valid
);
  localparam int LAT  = MUL_LAT + 3;
  localparam int CW   = $clog2(LAT + 8) + 1;
  localparam wide_t OMAX = (wide_t'(1) <<< (OW - 1)) - wide_t'(1);

  wide_t p_g, i_g, p_i;
  logic  v_g, v_i;
  logic signed [OW-1:0] acc;
  logic  sat_hi, sat_lo;

  pi_gain_stage #(.IW(IW), .GW(GW), .FRAC(FRAC), .MUL_LAT(MUL_LAT)) u_gain (
    .clk    (clk),
    .rst    (rst),
    .strobe (smp_strobe),
    .sp     (setpoint),
    .meas   (measured),
    .kp     (kp),
    .ki     (ki),
    .p_term (p_g),
    .i_term (i_g),
    .v_out  (v_g)
  );

  pi_integrator #(.OW(OW)) u_integ (
    .clk    (clk),
    .rst    (rst),
    .v_in   (v_g),
    .p_in   (p_g),
    .i_in   (i_g),
    .sat_hi (sat_hi),
    .sat_lo (sat_lo),
    .acc    (acc),
    .p_out  (p_i),
    .v_out  (v_i)
  );

  wide_t tot;
  assign tot = clamp(p_i + wide_t'(acc), OW);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_out   <= '0;
      ctl_valid <= 1'b0;
      sat_hi    <= 1'b0;
      sat_lo    <= 1'b0;
    end else begin
      ctl_valid <= v_i;
      if (v_i) begin
        ctl_out <= OW'(tot);
        sat_hi  <= (tot == OMAX);
        sat_lo  <= (tot == -OMAX - wide_t'(1));
      end
    end
  end

  logic [CW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst) since_q <= '0;
    else if (smp_strobe) since_q <= CW'(1);
    else if (since_q != '0 && since_q != '1) since_q <= since_q + CW'(1);
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    ctl_valid |-> since_q == CW'(LAT));
  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ctl_valid |=> !ctl_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl_valid |-> $stable(ctl_out));
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (ctl_out == '0 && !ctl_valid));
endmodule

// File: tb/sim_pi_ctrl.sv
module sim_pi_ctrl;
  localparam int CLK_NS  = 10;
  localparam int IW      = 16;
  localparam int GW      = 12;
  localparam int FRAC    = 4;
  localparam int OW      = 18;
  localparam int MUL_LAT = 3;
  localparam int EDGE_AT = MUL_LAT + 2;
  localparam longint OMAX = (longint'(1) <<< (OW - 1)) - 1;
  localparam longint OMIN = -OMAX - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_strobe = 1'b0;
  logic signed [IW-1:0] setpoint = '0, measured = '0;
  logic signed [GW-1:0] kp = '0, ki = '0;
  logic signed [OW-1:0] ctl_out;
  logic ctl_valid;

  int total = 0, bad = 0;
  longint m_acc = 0;
  bit m_hi = 0, m_lo = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  pi_ctrl #(.IW(IW), .GW(GW), .FRAC(FRAC), .OW(OW), .MUL_LAT(MUL_LAT)) u0 (
    .clk(clk), .rst(rst), .smp_strobe(smp_strobe), .setpoint(setpoint),
    .measured(measured), .kp(kp), .ki(ki), .ctl_out(ctl_out), .ctl_valid(ctl_valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint rnd(input longint x);
    return (x + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
  endfunction

  function automatic longint sat(input longint x);
    if (x > OMAX) return OMAX;
    if (x < OMIN) return OMIN;
    return x;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(ctl_out == 0, "R9 out cleared", ctl_out, 0);
    check(ctl_valid == 0, "R9 valid cleared", ctl_valid, 0);
    rst = 1'b0;
    m_acc = 0; m_hi = 0; m_lo = 0;
  endtask

  task automatic run_sample(input longint s, input longint m, input longint p, input longint i);
    longint err, pt, it, expo;
    logic signed [OW-1:0] held;
    err = s - m;
    pt = rnd(err * p);
    it = rnd(err * i);
    if (!((m_hi && it > 0) || (m_lo && it < 0))) m_acc = sat(m_acc + it);
    expo = sat(pt + m_acc);
    m_hi = (expo == OMAX);
    m_lo = (expo == OMIN);
    @(negedge clk);
    setpoint = IW'(s); measured = IW'(m); kp = GW'(p); ki = GW'(i);
    smp_strobe = 1'b1;
    @(negedge clk);
    smp_strobe = 1'b0;
    setpoint = ~setpoint; measured = measured ^ 16'h5a5a; kp = ~kp; ki = -ki;  // R1: must not matter
    held = ctl_out;
    for (int j = 0; j <= EDGE_AT; j++) begin
      if (j < EDGE_AT) begin
        check(ctl_valid == 0, "R7 early valid", ctl_valid, 0);
        check(ctl_out == held, "R8 hold before update", ctl_out, held);
        @(negedge clk);
      end else begin
        check(ctl_valid == 1, "R7 valid at latency", ctl_valid, 1);
        check(longint'(ctl_out) == expo, "R5 R2 R4 R6 value", ctl_out, expo);
      end
    end
    @(negedge clk);
    check(ctl_valid == 0, "R7 single-cycle pulse", ctl_valid, 0);
    check(longint'(ctl_out) == expo, "R8 hold after update", ctl_out, expo);
  endtask

  task automatic idle_no_strobe(input int n);
    logic signed [OW-1:0] held;
    held = ctl_out;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      setpoint = IW'(k * 977); measured = IW'(-k * 311); ki = GW'(k * 13);
      check(ctl_valid == 0, "R3 no valid without strobe", ctl_valid, 0);
      check(ctl_out == held, "R3 R8 no update without strobe", ctl_out, held);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // near-exhaustive sweep over error patterns and small gains (R1, R2, R5)
    for (int a = 0; a < 8; a++) begin
      for (int g = -3; g <= 3; g++) begin
        for (int h = -2; h <= 2; h++) begin
          run_sample((a * 37) - 100 + (a % 2) * 9, (a * a) - 20, g * 7 + 1, h * 3);
        end
      end
      do_reset();
    end
    // rounding ties: err*gain fraction exactly one half (R2)
    run_sample(1, 0, 8, 0);
    run_sample(-1, 0, 8, 0);
    run_sample(3, 0, 8, 0);
    idle_no_strobe(6);
    // extreme error without overflow (R1)
    do_reset();
    run_sample(32767, -32768, 1, 0);
    run_sample(-32768, 32767, 1, 0);
    // drive to positive saturation and windup block (R4, R6)
    do_reset();
    for (int k = 0; k < 6; k++) run_sample(30000, -30000, 0, 2047);
    run_sample(1000, 0, 0, 100);
    run_sample(-2000, 0, 0, 500);
    // negative saturation (R4, R6)
    for (int k = 0; k < 8; k++) run_sample(-30000, 30000, 100, 2047);
    run_sample(0, 500, 0, 40);
    run_sample(700, 0, -50, 60);
    idle_no_strobe(10);
    do_reset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule